// File: doc/BRIEF.md
# Page Refresh Sequencer

This block refreshes one page of a page-buffered flash array. It copies the page into the SRAM buffer, erases the page to all ones, and then programs the page again from the buffer. The SPI front end does the bit shifting and decoding. It passes in a decoded opcode and a page number through a one-cycle command strobe. The front end takes the page from a 24-bit address field: six reserved bits, then nine page bits, then nine don't-care bits.

The refresh opcode is 0x58. A command with this opcode arms the sequencer. The sequence starts only when chip select goes from low to high. The sequence runs through the states IDLE, XFER, ERASE, PROG and DONE, and then returns to IDLE. The `busy` output is high from XFER through DONE.

The transitions are:
- IDLE→XFER: armed and a chip-select rising edge.
- XFER→ERASE: the transfer window has elapsed.
- ERASE→PROG: the erase window has elapsed.
- PROG→DONE: the program window has elapsed.
- DONE→IDLE: always, after one cycle.

Let L_X = max(`XFER_CYCLES`, `PAGE_BYTES`) and L_P = max(`PROG_CYCLES`, `PAGE_BYTES`). These are the XFER and PROG window lengths used below.

Top module: `page_refresh_seq`

## Requirements
- R1: After reset, `busy`, `arr_rd`, `arr_we`, `arr_erase` and `buf_we` are all 0.
- R2: A `cmd_valid` strobe with `cmd_op` = 0x58, seen while idle, arms the sequencer and captures `cmd_page`.
  - A later 0x58 command replaces the captured page.
  - A command with any other opcode, seen while idle, clears the arm.
  - A command with any other opcode never starts a sequence.
- R3: A sequence starts only when armed and at a clock edge where `cs_n` is sampled high after being sampled low on the previous edge. `busy` is 1 from the following cycle. Holding `cs_n` low, or a `cs_n` rise while not armed, starts nothing.
- R4: XFER lasts L_X cycles. In XFER cycle k, for k < `PAGE_BYTES`, `arr_rd` and `buf_we` are 1 with column and buffer address k. The buffer write data is `arr_rdata`.
- R5: ERASE lasts `ERASE_CYCLES` cycles. `arr_erase` is high only in its first cycle, that is, cycle L_X of the sequence, with the captured page on `arr_page`.
- R6: PROG lasts L_P cycles. In PROG cycle k, for k < `PAGE_BYTES`, `arr_we` is 1 with column and buffer address k. The array write data is `buf_rdata`. The first write falls in cycle L_X + `ERASE_CYCLES` of the sequence.
- R7: DONE lasts one cycle and then the block returns to IDLE. `busy` stays high without a gap for exactly L_X + `ERASE_CYCLES` + L_P + 1 cycles.
- R8: A `cmd_valid` strobe while `busy` is high is ignored. It leaves no arm behind.
- R9: When the sequence ends, the page holds its original contents, the buffer holds the same bytes, no other page has changed, and `arr_page` stayed constant.
- R10: A completed sequence consumes the arm. A further `cs_n` rise without a new command starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle decoded command strobe |
| cmd_op | input | 8 | Decoded opcode |
| cmd_page | input | PAGE_W | Page number from the command |
| cs_n | input | 1 | Chip select, active low |
| busy | output | 1 | Sequence in progress |
| arr_page | output | PAGE_W | Array page address |
| arr_col | output | COL_W | Array column address |
| arr_rd | output | 1 | Array read strobe |
| arr_rdata | input | DATA_W | Array read data, combinational |
| arr_erase | output | 1 | One-cycle page erase request |
| arr_we | output | 1 | Array byte write strobe |
| arr_wdata | output | DATA_W | Array write data |
| buf_addr | output | COL_W | Buffer address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | DATA_W | Buffer write data |
| buf_rdata | input | DATA_W | Buffer read data, combinational |

## Verification
`busy` is registered. It rises in the first cycle after the clock edge that samples `cs_n` high after a low sample. That is two edges after `cs_n` is driven low and then high on successive negative edges.

All other outputs follow the state and the phase counter combinationally. The erase strobe is therefore due exactly L_X cycles after `busy` rises. The first array write is due L_X + `ERASE_CYCLES` cycles after `busy` rises.

The bench drives inputs and samples outputs on falling edges, once per cycle, starting at the cycle where `busy` must first read 1. It indexes every strobe by its cycle offset from that point.

// File: rtl/page_refresh_pkg.sv
package page_refresh_pkg;

    typedef enum logic [2:0] {
        RF_IDLE,
        RF_XFER,
        RF_ERASE,
        RF_PROG,
        RF_DONE
    } rf_state_e;

    localparam logic [7:0] OP_REFRESH = 8'h58;

endpackage

// File: rtl/refresh_cmd_latch.sv
module refresh_cmd_latch
    import page_refresh_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              cs_n,
    input  logic              idle,
    output logic              start,
    output logic [PAGE_W-1:0] page
);

    logic cs_q;
    logic armed_q;

    // Launch: armed, idle, and chip select seen rising.
    assign start = armed_q && idle && cs_n && !cs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            armed_q <= 1'b0;
            page    <= '0;
        end else begin
            cs_q <= cs_n;
            if (start) begin
                armed_q <= 1'b0;
            end else if (cmd_valid && idle) begin
                if (cmd_op == OP_REFRESH) begin
                    armed_q <= 1'b1;
                    page    <= cmd_page;
                end else begin
                    armed_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/refresh_phase_timer.sv
module refresh_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/page_refresh_seq.sv
module page_refresh_seq
    import page_refresh_pkg::*;
#(
    parameter int PAGE_W      = 9,
    parameter int PAGE_BYTES  = 264,
    parameter int DATA_W      = 8,
    parameter int XFER_CYCLES = 1200,
    parameter int ERASE_CYCLES = 3000,
    parameter int PROG_CYCLES = 4000,
    localparam int COL_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              cs_n,
    output logic              busy,
    output logic [PAGE_W-1:0] arr_page,
    output logic [COL_W-1:0]  arr_col,
    output logic              arr_rd,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_erase,
    output logic              arr_we,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [COL_W-1:0]  buf_addr,
    output logic              buf_we,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic [DATA_W-1:0] buf_rdata
);

    localparam int XFER_LEN  = (XFER_CYCLES > PAGE_BYTES) ? XFER_CYCLES : PAGE_BYTES;
    localparam int PROG_LEN  = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;
    localparam int ERASE_LEN = (ERASE_CYCLES > 0) ? ERASE_CYCLES : 1;
    localparam int MAX_A     = (XFER_LEN > PROG_LEN) ? XFER_LEN : PROG_LEN;
    localparam int MAX_LEN   = (MAX_A > ERASE_LEN) ? MAX_A : ERASE_LEN;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    rf_state_e         state_q, state_d;
    logic              start;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  cnt;
    logic              in_page;

    refresh_cmd_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_page  (cmd_page),
        .cs_n      (cs_n),
        .idle      (state_q == RF_IDLE),
        .start     (start),
        .page      (page_q)
    );

    refresh_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != RF_IDLE),
        .restart (state_d != state_q),
        .count   (cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RF_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_IDLE:  if (start) state_d = RF_XFER;
            RF_XFER:  if (cnt == CNT_W'(XFER_LEN - 1)) state_d = RF_ERASE;
            RF_ERASE: if (cnt == CNT_W'(ERASE_LEN - 1)) state_d = RF_PROG;
            RF_PROG:  if (cnt == CNT_W'(PROG_LEN - 1)) state_d = RF_DONE;
            RF_DONE:  state_d = RF_IDLE;
            default:  state_d = RF_IDLE;
        endcase
    end

    assign in_page = (cnt < CNT_W'(PAGE_BYTES));

    // Outputs
    always_comb begin
        busy      = 1'b0;
        arr_rd    = 1'b0;
        arr_erase = 1'b0;
        arr_we    = 1'b0;
        buf_we    = 1'b0;
        arr_page  = page_q;
        arr_col   = cnt[COL_W-1:0];
        buf_addr  = cnt[COL_W-1:0];
        buf_wdata = arr_rdata;
        arr_wdata = buf_rdata;
        unique case (state_q)
            RF_IDLE: ;
            RF_XFER: begin
                busy   = 1'b1;
                arr_rd = in_page;
                buf_we = in_page;
            end
            RF_ERASE: begin
                busy      = 1'b1;
                arr_erase = (cnt == '0);
            end
            RF_PROG: begin
                busy   = 1'b1;
                arr_we = in_page;
            end
            RF_DONE: busy = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/page_refresh_seq_chk.sv
module page_refresh_seq_chk
    import page_refresh_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cs_n,
    input logic              arr_rd,
    input logic              arr_we,
    input logic              arr_erase,
    input logic              buf_we,
    input logic [PAGE_W-1:0] arr_page,
    input rf_state_e         state
);

    logic seen_copy, seen_erase;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            seen_copy  <= 1'b0;
            seen_erase <= 1'b0;
        end else begin
            if (buf_we)    seen_copy  <= 1'b1;
            if (arr_erase) seen_erase <= 1'b1;
        end
    end

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(arr_rd || arr_we || arr_erase || buf_we));

    a_r3_start_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2)));

    a_r4_no_mixed_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && arr_we));

    a_r5_erase_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |-> seen_copy);

    a_r5_single_erase: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |=> !arr_erase);

    a_r6_write_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> seen_erase);

    a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state) == RF_DONE));

    a_r9_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_page));

endmodule

bind page_refresh_seq page_refresh_seq_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cs_n      (cs_n),
    .arr_rd    (arr_rd),
    .arr_we    (arr_we),
    .arr_erase (arr_erase),
    .buf_we    (buf_we),
    .arr_page  (arr_page),
    .state     (state_q)
);

// File: tb/test_page_refresh_seq.sv
module test_page_refresh_seq;

    localparam int PW = 9;
    localparam int PB = 264;
    localparam int CW = $clog2(PB);
    localparam int NP = 1 << PW;
    localparam int XC = 300;
    localparam int EC = 40;
    localparam int PC = 280;
    localparam int XL = (XC > PB) ? XC : PB;
    localparam int PL = (PC > PB) ? PC : PB;
    localparam int TOTAL = XL + EC + PL + 1;

    // {opcode, page, expect_run}
    localparam logic [17:0] VEC [0:5] = '{
        {8'h58, 9'd0,   1'b1},
        {8'h58, 9'd511, 1'b1},
        {8'h53, 9'd3,   1'b0},
        {8'h58, 9'h0AA, 1'b1},
        {8'h82, 9'd7,   1'b0},
        {8'h58, 9'd300, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_op = '0;
    logic [PW-1:0] cmd_page = '0;
    logic cs_n = 1'b1;
    logic busy, arr_rd, arr_erase, arr_we, buf_we;
    logic [PW-1:0] arr_page;
    logic [CW-1:0] arr_col, buf_addr;
    logic [7:0] arr_rdata, arr_wdata, buf_wdata, buf_rdata;

    logic [7:0] mem [0:NP*PB-1];
    logic [7:0] bufm [0:PB-1];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    page_refresh_seq #(
        .PAGE_W(PW), .PAGE_BYTES(PB), .DATA_W(8),
        .XFER_CYCLES(XC), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)
    ) i_page_refresh_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .cs_n(cs_n), .busy(busy), .arr_page(arr_page),
        .arr_col(arr_col), .arr_rd(arr_rd), .arr_rdata(arr_rdata),
        .arr_erase(arr_erase), .arr_we(arr_we), .arr_wdata(arr_wdata),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'((p * 7) + (c * 13) + 5);
    endfunction

    assign arr_rdata = mem[int'(arr_page) * PB + int'(arr_col)];
    assign buf_rdata = bufm[int'(buf_addr)];

    // Behavioural array and buffer
    always @(posedge clk) begin
        if (arr_erase)
            for (int c = 0; c < PB; c++) mem[int'(arr_page) * PB + c] = 8'hFF;
        if (arr_we)
            mem[int'(arr_page) * PB + int'(arr_col)] = arr_wdata;
        if (buf_we)
            bufm[int'(buf_addr)] = buf_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [PW-1:0] pg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_cs();
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic observe(input bit run, input int pg, input int inject);
        int k = 0, er_k = -1, er_cnt = 0, er_pg = -1, we_k = -1, we_cnt = 0;
        int bw_cnt = 0, rd_cnt = 0, bad = 0, bad_buf = 0, bad_nb = 0, nb;
        @(negedge clk);
        if (!run) begin
            for (int i = 0; i < 20; i++) begin
                if (busy || arr_we || arr_erase || buf_we || arr_rd) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R2/R3/R8/R10 no start", bad, 0);
            return;
        end
        chk(busy == 1'b1, "R3 busy after cs rise", int'(busy), 1);
        while (busy && k < 20000) begin
            if (k == inject) begin
                cmd_valid = 1'b1; cmd_op = 8'h58; cmd_page = 9'd20;
            end else if (k == inject + 1) begin
                cmd_valid = 1'b0;
            end
            if (arr_erase) begin
                er_cnt++;
                if (er_k < 0) begin er_k = k; er_pg = int'(arr_page); end
            end
            if (arr_we) begin
                we_cnt++;
                if (we_k < 0) we_k = k;
            end
            if (buf_we) bw_cnt++;
            if (arr_rd) rd_cnt++;
            k++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(k == TOTAL, "R7 busy length", k, TOTAL);
        chk(bw_cnt == PB && rd_cnt == PB, "R4 copy count", bw_cnt, PB);
        chk(er_cnt == 1 && er_k == XL, "R5 erase timing", er_k, XL);
        chk(er_pg == pg, "R5 erase page", er_pg, pg);
        chk(we_cnt == PB && we_k == XL + EC, "R6 program timing", we_k, XL + EC);
        nb = pg ^ 1;
        for (int c = 0; c < PB; c++) begin
            if (mem[pg * PB + c] !== pat(pg, c)) bad++;
            if (bufm[c] !== pat(pg, c)) bad_buf++;
            if (mem[nb * PB + c] !== pat(nb, c)) bad_nb++;
        end
        chk(bad == 0, "R9 page restored", bad, 0);
        chk(bad_buf == 0, "R4/R9 buffer holds page", bad_buf, 0);
        chk(bad_nb == 0, "R9 neighbour untouched", bad_nb, 0);
    endtask

    task automatic prefill_buffer();
        for (int c = 0; c < PB; c++) bufm[c] = 8'hA5;
    endtask

    initial begin
        for (int i = 0; i < NP * PB; i++) mem[i] = pat(i / PB, i % PB);
        prefill_buffer();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !arr_we && !arr_erase && !buf_we && !arr_rd,
            "R1 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        // R3: cs rise with nothing armed
        pulse_cs();
        observe(1'b0, 0, -1);

        // Vector table
        for (int v = 0; v < 6; v++) begin
            prefill_buffer();
            send_cmd(VEC[v][17:10], VEC[v][9:1]);
            pulse_cs();
            observe(VEC[v][0], int'(VEC[v][9:1]), -1);
        end

        // R8: command during busy is ignored
        prefill_buffer();
        send_cmd(8'h58, 9'd10);
        pulse_cs();
        observe(1'b1, 10, 50);
        pulse_cs();
        observe(1'b0, 0, -1);

        // R10: arm consumed
        prefill_buffer();
        send_cmd(8'h58, 9'd11);
        pulse_cs();
        observe(1'b1, 11, -1);
        pulse_cs();
        observe(1'b0, 0, -1);

        // R2: latest refresh command wins
        prefill_buffer();
        send_cmd(8'h58, 9'd40);
        send_cmd(8'h58, 9'd41);
        pulse_cs();
        observe(1'b1, 41, -1);

        // R2: other opcode cancels arm
        send_cmd(8'h58, 9'd50);
        send_cmd(8'h0B, 9'd0);
        pulse_cs();
        observe(1'b0, 0, -1);

        // R3: cs held low does not start
        send_cmd(8'h58, 9'd60);
        @(negedge clk); cs_n = 1'b0;
        observe(1'b0, 0, -1);
        @(negedge clk); cs_n = 1'b1;
        observe(1'b1, 60, -1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule